// File: doc/BRIEF.md
# Cipher Key Store

This block keeps the two keys of a block-cipher peripheral. One is a long-lived master key. The other is the working key that the cipher engine uses for every block. A bus decoder, which is not part of this block, presents byte writes. Each write carries a kind bit that selects where the key goes. A master load fills the master key and the working key together. A working-only load fills only the working key. Each byte carries its own odd-parity bit, and every incoming byte is checked against it.

A transfer request copies the master key into the working key, one byte per cycle, over eight cycles. The cipher engine, which is also outside this block, can return a key it has enciphered or deciphered. A strobe writes that key into the working key in a single cycle, and its parity is checked on arrival. While the engine runs, the working key is rechecked on every cycle. Any parity failure raises a sticky flag and pulls an active-low interrupt low. Only a hardware or software reset clears the flag.

Neither kind of reset touches the key contents. However, a reset that arrives during an operation leaves the working key half-built. In that case the working-key valid flag is cleared. An operation here means a partial load, a transfer or an engine run.

Top module: `cipher_key_store`

## Requirements
- R1: Eight accepted writes with `wrKind`=1 (master) place byte k of the sequence in bits [63-8k -: 8] of both `masterKey` and `workKey`. Byte 0 lands in the top byte.
- R2: Eight accepted writes with `wrKind`=0 fill `workKey` in the same byte order and leave `masterKey` unchanged.
- R3: A byte is good when it has an odd number of ones, with bit 0 acting as the parity bit. An accepted written byte that has even parity sets `parityErr` and drives `parityIrqN` low on the cycle after the write.
- R4: `parityErr` stays set until a hardware reset (`rstN` low) or a software reset (`softRst` high). Either reset clears it on the next cycle.
- R5: An accepted `xferReq` raises `xferBusy` for exactly 8 cycles. In the n-th busy cycle, master byte n-1 is copied into `workKey`, top byte first. At the end, `workKey` equals `masterKey`, the master key is unchanged, and `workKeyValid` is 1.
- R6: While `xferBusy` or `engBusy` is high, byte writes and `xferReq` are ignored. If `xferReq` is accepted, a write in the same cycle is ignored.
- R7: `engKeyStrobe` loads `engKey` into `workKey` in one cycle, unless a transfer is busy. The load sets `workKeyValid`, and an even-parity byte in `engKey` sets `parityErr`.
- R8: While `engBusy` is high, any even-parity byte in `workKey` sets `parityErr` on the next cycle.
- R9: Hardware and software resets leave `masterKey` and `workKey` unchanged.
- R10: A reset during a partial load, a transfer or an engine run clears `workKeyValid`. A reset taken while idle keeps it.
- R11: A write whose kind differs from the load in progress restarts the sequence at byte 0 of the new kind.
- R12: `workKeyValid` falls on the first byte of a load and rises with the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous hardware reset, active low |
| softRst | input | 1 | Software reset pulse |
| wrEn | input | 1 | Byte write strobe |
| wrKind | input | 1 | 1: master load, 0: working-only load |
| wrByte | input | 8 | Key byte with its parity bit in bit 0 |
| xferReq | input | 1 | Request to copy the master key to the working key |
| engBusy | input | 1 | Cipher engine is processing |
| engKeyStrobe | input | 1 | Engine key result is valid |
| engKey | input | 64 | Engine key result |
| masterKey | output | 64 | Master key |
| workKey | output | 64 | Working key |
| workKeyValid | output | 1 | Working key is complete and trustworthy |
| xferBusy | output | 1 | Transfer in progress |
| parityErr | output | 1 | Sticky parity-error flag |
| parityIrqN | output | 1 | Parity interrupt, active low |

## Verification
A corrupted byte counter writes the next byte into the wrong lane. That error appears in `workKey` on the cycle after the write, and `workKeyValid` then rises early or late. A stuck transfer counter shows up as a `xferBusy` pulse that is not eight cycles long, or as a partial copy that can be read from `workKey` halfway through the run. A lost sticky bit, or a missing invalidation on reset, shows on `parityErr` or `workKeyValid` one cycle after the stimulus. The tests therefore sample these outputs at each of those cycles.

// File: rtl/cipher_key_store_pkg.sv
package cipher_key_store_pkg;
  localparam int KeyBytes = 8;
  localparam int ByteW    = 8;
  localparam int KeyW     = KeyBytes * ByteW;
  localparam int IdxW     = $clog2(KeyBytes);

  typedef logic [IdxW-1:0] byteIdx_t;

  typedef enum logic {
    KIND_WORK   = 1'b0,
    KIND_MASTER = 1'b1
  } loadKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrMaster;
    logic     wrWork;
    byteIdx_t wrIdx;
    logic     xferCopy;
    byteIdx_t xferIdx;
    logic     engLoad;
    logic     invalidate;
    logic     validate;
    logic     clrErr;
  } keyStrobes_t;

  // odd parity: a good byte has an odd count of ones
  function automatic logic oddOk(input logic [ByteW-1:0] b);
    return ^b;
  endfunction

  // lsb position of lane idx, lane 0 is the top byte
  function automatic int laneLsb(input byteIdx_t idx);
    return ByteW * (KeyBytes - 1 - int'(idx));
  endfunction
endpackage

// File: rtl/cipher_key_store_ctrl.sv
module cipher_key_store_ctrl
  import cipher_key_store_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        wrEn,
  input  loadKind_t   wrKind,
  input  logic        xferReq,
  input  logic        engBusy,
  input  logic        engKeyStrobe,
  output keyStrobes_t strobes,
  output logic        xferBusy
);
  localparam byteIdx_t LastIdx = byteIdx_t'(KeyBytes - 1);

  logic      seqActive;
  loadKind_t seqKind;
  byteIdx_t  seqCnt;
  logic      xferBusyQ;
  byteIdx_t  xferCnt;

  logic     resetNow, opActive, blocked;
  logic     xferStart, wrAccept, engAccept, restart;
  byteIdx_t curIdx;

  assign resetNow  = !rstN || softRst;
  assign opActive  = seqActive || xferBusyQ || engBusy;
  assign blocked   = xferBusyQ || engBusy;
  assign xferStart = xferReq && !blocked && !resetNow;
  assign wrAccept  = wrEn && !blocked && !xferReq && !resetNow;
  assign engAccept = engKeyStrobe && !xferBusyQ && !resetNow;
  assign restart   = !seqActive || (wrKind != seqKind);
  assign curIdx    = restart ? '0 : seqCnt;

  always_comb begin
    strobes            = '0;
    strobes.wrWork     = wrAccept;
    strobes.wrMaster   = wrAccept && (wrKind == KIND_MASTER);
    strobes.wrIdx      = curIdx;
    strobes.xferCopy   = xferBusyQ && !resetNow;
    strobes.xferIdx    = xferCnt;
    strobes.engLoad    = engAccept;
    strobes.invalidate = (resetNow && opActive) || xferStart ||
                         (wrAccept && curIdx == '0);
    strobes.validate   = (wrAccept && curIdx == LastIdx) ||
                         (xferBusyQ && !resetNow && xferCnt == LastIdx) ||
                         engAccept;
    strobes.clrErr     = resetNow;
  end

  always_ff @(posedge clk) begin
    if (resetNow) begin
      seqActive <= 1'b0;
      seqCnt    <= '0;
      seqKind   <= KIND_WORK;
      xferBusyQ <= 1'b0;
      xferCnt   <= '0;
    end else begin
      if (xferStart) begin
        xferBusyQ <= 1'b1;
        xferCnt   <= '0;
      end else if (xferBusyQ) begin
        xferCnt <= xferCnt + 1'b1;
        if (xferCnt == LastIdx) xferBusyQ <= 1'b0;
      end

      if (engAccept || xferStart) begin
        seqActive <= 1'b0;
        seqCnt    <= '0;
      end else if (wrAccept) begin
        seqKind   <= wrKind;
        seqCnt    <= curIdx + 1'b1;
        seqActive <= (curIdx != LastIdx);
      end
    end
  end

  assign xferBusy = xferBusyQ;
endmodule

// File: rtl/cipher_key_store_dp.sv
module cipher_key_store_dp
  import cipher_key_store_pkg::*;
(
  input  logic               clk,
  input  keyStrobes_t        strobes,
  input  logic [ByteW-1:0]   wrByte,
  input  logic [KeyW-1:0]    engKey,
  input  logic               engBusy,
  output logic [KeyW-1:0]    masterKey,
  output logic [KeyW-1:0]    workKey,
  output logic               workValid,
  output logic               parityErr
);
  logic [KeyBytes-1:0] engLaneOk;
  logic [KeyBytes-1:0] workLaneOk;
  logic                errHit;

  for (genvar g = 0; g < KeyBytes; g++) begin : gLane
    assign engLaneOk[g]  = oddOk(engKey[g*ByteW +: ByteW]);
    assign workLaneOk[g] = oddOk(workKey[g*ByteW +: ByteW]);
  end

  assign errHit = (strobes.wrWork && !oddOk(wrByte)) ||
                  (strobes.engLoad && !(&engLaneOk)) ||
                  (engBusy && !(&workLaneOk));

  // key storage carries no reset: both resets must preserve it
  always_ff @(posedge clk) begin
    if (strobes.wrMaster)
      masterKey[laneLsb(strobes.wrIdx) +: ByteW] <= wrByte;
    if (strobes.engLoad)
      workKey <= engKey;
    else if (strobes.xferCopy)
      workKey[laneLsb(strobes.xferIdx) +: ByteW] <=
        masterKey[laneLsb(strobes.xferIdx) +: ByteW];
    else if (strobes.wrWork)
      workKey[laneLsb(strobes.wrIdx) +: ByteW] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (strobes.invalidate)    workValid <= 1'b0;
    else if (strobes.validate) workValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.clrErr)  parityErr <= 1'b0;
    else if (errHit)     parityErr <= 1'b1;
  end
endmodule

// File: rtl/cipher_key_store.sv
module cipher_key_store
  import cipher_key_store_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               wrEn,
  input  logic               wrKind,
  input  logic [ByteW-1:0]   wrByte,
  input  logic               xferReq,
  input  logic               engBusy,
  input  logic               engKeyStrobe,
  input  logic [KeyW-1:0]    engKey,
  output logic [KeyW-1:0]    masterKey,
  output logic [KeyW-1:0]    workKey,
  output logic               workKeyValid,
  output logic               xferBusy,
  output logic               parityErr,
  output logic               parityIrqN
);
  keyStrobes_t strobes;

  cipher_key_store_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .softRst      (softRst),
    .wrEn         (wrEn),
    .wrKind       (loadKind_t'(wrKind)),
    .xferReq      (xferReq),
    .engBusy      (engBusy),
    .engKeyStrobe (engKeyStrobe),
    .strobes      (strobes),
    .xferBusy     (xferBusy)
  );

  cipher_key_store_dp uDp (
    .clk       (clk),
    .strobes   (strobes),
    .wrByte    (wrByte),
    .engKey    (engKey),
    .engBusy   (engBusy),
    .masterKey (masterKey),
    .workKey   (workKey),
    .workValid (workKeyValid),
    .parityErr (parityErr)
  );

  assign parityIrqN = !parityErr;
endmodule

// File: rtl/cipher_key_store_chk.sv
module cipher_key_store_chk
  import cipher_key_store_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               softRst,
  input logic               wrEn,
  input logic [ByteW-1:0]   wrByte,
  input logic               xferReq,
  input logic               engBusy,
  input logic [KeyW-1:0]    masterKey,
  input logic [KeyW-1:0]    workKey,
  input logic               workKeyValid,
  input logic               xferBusy,
  input logic               parityErr
);
  logic [IdxW:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)         busyLen <= '0;
    else if (xferBusy) busyLen <= busyLen + 1'b1;
    else               busyLen <= '0;
  end

  assert_bad_byte_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !xferBusy && !engBusy && !xferReq && !softRst && !(^wrByte)) |=> parityErr);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !softRst) |=> parityErr);

  assert_xfer_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> (busyLen < (IdxW+1)'(KeyBytes)));

  assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(xferBusy) && !$past(softRst) && $past(rstN)) |-> (workKey == masterKey && workKeyValid));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (engBusy || xferBusy) |=> $stable(masterKey));

  assert_soft_keeps_keys_R9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> ($stable(masterKey) && $stable(workKey)));

  assert_abort_invalidates_R10: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && xferBusy) |=> !workKeyValid);
endmodule

bind cipher_key_store cipher_key_store_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .softRst      (softRst),
  .wrEn         (wrEn),
  .wrByte       (wrByte),
  .xferReq      (xferReq),
  .engBusy      (engBusy),
  .masterKey    (masterKey),
  .workKey      (workKey),
  .workKeyValid (workKeyValid),
  .xferBusy     (xferBusy),
  .parityErr    (parityErr)
);

// File: tb/cipher_key_store_test.sv
module cipher_key_store_test;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrKind = 1'b0;
  logic [7:0]  wrByte = '0;
  logic        xferReq = 1'b0;
  logic        engBusy = 1'b0;
  logic        engKeyStrobe = 1'b0;
  logic [63:0] engKey = '0;
  logic [63:0] masterKey, workKey;
  logic        workKeyValid, xferBusy, parityErr, parityIrqN;

  int checks = 0;
  int errors = 0;

  always #(ClkPeriod/2) clk = ~clk;

  cipher_key_store uut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrKind(wrKind),
    .wrByte(wrByte), .xferReq(xferReq), .engBusy(engBusy),
    .engKeyStrobe(engKeyStrobe), .engKey(engKey), .masterKey(masterKey),
    .workKey(workKey), .workKeyValid(workKeyValid), .xferBusy(xferBusy),
    .parityErr(parityErr), .parityIrqN(parityIrqN)
  );

  function automatic logic [63:0] fixOdd(input logic [63:0] k);
    logic [63:0] r = k;
    for (int i = 0; i < 8; i++) r[i*8] = ~^k[i*8+1 +: 7];
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeByte(input logic kind, input logic [7:0] b);
    wrEn = 1'b1; wrKind = kind; wrByte = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadKey(input logic kind, input logic [63:0] k);
    for (int i = 0; i < 8; i++) writeByte(kind, k[63-8*i -: 8]);
  endtask

  task automatic softPulse();
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
  endtask

  task automatic hardPulse();
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
  endtask

  logic [63:0] keyA, keyB, keyC, keyD;

  task automatic testResetState();
    check(parityErr == 1'b0, "R4 reset flag", 64'(parityErr), 64'd0);
    check(parityIrqN == 1'b1, "R4 reset irq", 64'(parityIrqN), 64'd1);
    check(xferBusy == 1'b0, "R5 reset busy", 64'(xferBusy), 64'd0);
  endtask

  task automatic testMasterLoad();
    writeByte(1'b1, keyA[63:56]);
    check(workKeyValid == 1'b0, "R12 valid drops on byte 0", 64'(workKeyValid), 64'd0);
    for (int i = 1; i < 8; i++) writeByte(1'b1, keyA[63-8*i -: 8]);
    check(masterKey == keyA, "R1 master", masterKey, keyA);
    check(workKey == keyA, "R1 work", workKey, keyA);
    check(workKeyValid == 1'b1, "R12 valid after byte 7", 64'(workKeyValid), 64'd1);
    check(parityErr == 1'b0, "R3 good bytes no flag", 64'(parityErr), 64'd0);
  endtask

  task automatic testPlainLoad();
    loadKey(1'b0, keyB);
    check(workKey == keyB, "R2 work", workKey, keyB);
    check(masterKey == keyA, "R2 master kept", masterKey, keyA);
  endtask

  task automatic testTransfer();
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    check(xferBusy == 1'b1, "R5 busy starts", 64'(xferBusy), 64'd1);
    tick(4);
    check(workKey == {keyA[63:32], keyB[31:0]}, "R5 half copied",
          workKey, {keyA[63:32], keyB[31:0]});
    // R6: write and second request mid-transfer are ignored
    writeByte(1'b1, 8'h00);
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    tick(1);
    check(xferBusy == 1'b1, "R5 still busy at cycle 7", 64'(xferBusy), 64'd1);
    tick(1);
    check(xferBusy == 1'b0, "R6 not restarted", 64'(xferBusy), 64'd0);
    check(workKey == keyA, "R5 full copy", workKey, keyA);
    check(masterKey == keyA, "R6 master untouched", masterKey, keyA);
    check(workKeyValid == 1'b1, "R5 valid", 64'(workKeyValid), 64'd1);
  endtask

  task automatic testEngineBlocks();
    engBusy = 1'b1;
    writeByte(1'b1, 8'h01);
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    check(masterKey == keyA, "R6 write ignored while engine busy", masterKey, keyA);
    check(xferBusy == 1'b0, "R6 xfer ignored while engine busy", 64'(xferBusy), 64'd0);
    engBusy = 1'b0; @(negedge clk);
  endtask

  task automatic testEngineKey();
    engKey = keyC; engKeyStrobe = 1'b1; @(negedge clk); engKeyStrobe = 1'b0;
    check(workKey == keyC, "R7 engine key", workKey, keyC);
    check(workKeyValid == 1'b1, "R7 valid", 64'(workKeyValid), 64'd1);
    check(parityErr == 1'b0, "R7 good parity", 64'(parityErr), 64'd0);
    engKey = keyC ^ 64'h100; engKeyStrobe = 1'b1; @(negedge clk); engKeyStrobe = 1'b0;
    check(parityErr == 1'b1, "R7 bad engine key flags", 64'(parityErr), 64'd1);
    check(parityIrqN == 1'b0, "R7 irq low", 64'(parityIrqN), 64'd0);
    tick(5);
    check(parityErr == 1'b1, "R4 flag holds", 64'(parityErr), 64'd1);
    softPulse();
    check(parityErr == 1'b0, "R4 soft reset clears", 64'(parityErr), 64'd0);
    check(workKey == (keyC ^ 64'h100), "R9 soft keeps work", workKey, keyC ^ 64'h100);
    check(masterKey == keyA, "R9 soft keeps master", masterKey, keyA);
  endtask

  task automatic testBadByte();
    loadKey(1'b1, keyD);
    writeByte(1'b0, keyD[63:56] ^ 8'h01);
    check(parityErr == 1'b1, "R3 bad byte flags", 64'(parityErr), 64'd1);
    check(parityIrqN == 1'b0, "R3 irq low", 64'(parityIrqN), 64'd0);
    for (int i = 1; i < 8; i++) writeByte(1'b0, keyD[63-8*i -: 8]);
    hardPulse();
    check(parityErr == 1'b0, "R4 hard reset clears", 64'(parityErr), 64'd0);
    check(masterKey == keyD, "R9 hard keeps master", masterKey, keyD);
    check(workKey == (keyD ^ 64'h0100_0000_0000_0000), "R9 hard keeps work",
          workKey, keyD ^ 64'h0100_0000_0000_0000);
    check(workKeyValid == 1'b1, "R10 idle reset keeps valid", 64'(workKeyValid), 64'd1);
  endtask

  task automatic testContinuousCheck();
    // working key still holds a bad top byte from the previous test
    softPulse();
    check(parityErr == 1'b0, "R8 clear before run", 64'(parityErr), 64'd0);
    engBusy = 1'b1; @(negedge clk);
    check(parityErr == 1'b1, "R8 check during engine run", 64'(parityErr), 64'd1);
    engBusy = 1'b0; softPulse();
  endtask

  task automatic testAbort();
    for (int i = 0; i < 3; i++) writeByte(1'b0, keyB[63-8*i -: 8]);
    softPulse();
    check(workKeyValid == 1'b0, "R10 abort partial load", 64'(workKeyValid), 64'd0);
    loadKey(1'b0, keyB);
    engBusy = 1'b1; softRst = 1'b1; @(negedge clk);
    softRst = 1'b0; engBusy = 1'b0;
    check(workKeyValid == 1'b0, "R10 abort engine run", 64'(workKeyValid), 64'd0);
    loadKey(1'b0, keyB);
    xferReq = 1'b1; @(negedge clk); xferReq = 1'b0;
    tick(3);
    hardPulse();
    check(workKeyValid == 1'b0, "R10 abort transfer", 64'(workKeyValid), 64'd0);
    check(xferBusy == 1'b0, "R10 transfer stopped", 64'(xferBusy), 64'd0);
    check(masterKey == keyD, "R10 master kept", masterKey, keyD);
  endtask

  task automatic testRestart();
    for (int i = 0; i < 3; i++) writeByte(1'b1, keyA[63-8*i -: 8]);
    loadKey(1'b0, keyC);
    check(workKey == keyC, "R11 restart work", workKey, keyC);
    check(masterKey == {keyA[63:40], keyD[39:0]}, "R11 master partial",
          masterKey, {keyA[63:40], keyD[39:0]});
    check(workKeyValid == 1'b1, "R11 valid after restart", 64'(workKeyValid), 64'd1);
  endtask

  initial begin
    keyA = fixOdd(64'h0123_4567_89AB_CDEF);
    keyB = fixOdd(64'hFEDC_BA98_7654_3210);
    keyC = fixOdd(64'h1357_9BDF_0246_8ACE);
    keyD = fixOdd(64'hA5C3_5A3C_F00F_0FF0);
    tick(3);
    rstN = 1'b1;
    tick(1);
    testResetState();
    testMasterLoad();
    testPlainLoad();
    testTransfer();
    testEngineBlocks();
    testEngineKey();
    testBadByte();
    testContinuousCheck();
    testAbort();
    testRestart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(ClkPeriod * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule